// File: doc/BRIEF.md
# Serial Port FIFO Flag and Interrupt Controller

This block holds the status flags and the interrupt request lines of a serial port that has a transmit FIFO and a receive FIFO. It watches the fill counts of both FIFOs, the strobes that mark a word leaving the transmit FIFO or entering the receive FIFO, and the receive-side event pulses for data-ready, framing or parity errors, and break. From these it sets five status flags. Its 8-bit control register carries the two enables that gate four level interrupt outputs.

Software clears a flag with a handshake. It first reads the status register while the flag is 1, which arms a per-flag marker. It then writes 0 to that bit. For the two FIFO-level flags, the clear is also refused while the FIFO still sits on the wrong side of its trigger level. The trigger levels are chosen from four powers of two through 2-bit selects. The FIFOs themselves, the shift registers and the serial framing are outside the block. Their counts and events arrive as plain inputs.

Top module: `uart_flag_irq`

## Requirements
- R1: After reset the control register, all status flags and all four interrupt outputs are 0. The control register reads back what was last written. Bit 7 is the transmit interrupt enable and bit 6 is the receive interrupt enable.
- R2: The transmit-empty flag sets on a cycle with `txPop` high when `txCount` is below the transmit trigger level.
- R3: `txIrq` is a register equal to the transmit-empty flag ANDed with control bit 7, one clock after either changes. Clearing bit 7 drops `txIrq` while the flag stays set.
- R4: The transmit-empty flag clears only on a status write with bit 3 at 0, after an arming read, while `txCount` is above the transmit trigger level.
- R5: The receive-full flag sets on a cycle with `rxPush` high when `rxCount` is above the receive trigger level.
- R6: Control bit 6 gates `rxIrq` (receive-full OR data-ready), `errIrq` and `brkIrq`. Each is a register, one clock behind its flag or the enable. With bit 6 at 0 all three are 0.
- R7: The data-ready, receive-full, break and error flags clear by an arming read followed by a write of 0 to their bit. The receive-full clear is refused unless `rxCount` is below the receive trigger level.
- R8: A status read arms a marker for each flag that reads as 1. Any status write consumes all markers. A write of 0 to a flag whose marker is not armed leaves the flag set.
- R9: Writing 1 to a status bit has no effect. A hardware set event in the same cycle as an accepted clear leaves the flag set.
- R10: A trigger select value s gives a level of 1 << s words, so the selects 0, 1, 2 and 3 give 1, 2, 4 and 8.
- R11: Status bit positions are: bit 0 data-ready, bit 1 receive-full, bit 2 break, bit 3 transmit-empty, bit 4 error. Event pulses `rxDrEvt`, `rxErrEvt` and `rxBrkEvt` set their flags one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWrEn | input | 1 | Control register write strobe |
| ctrlWrData | input | 8 | Control register write data |
| ctrlRdData | output | 8 | Control register contents |
| statRdEn | input | 1 | Status register read strobe (arms markers) |
| statWrEn | input | 1 | Status register write strobe |
| statWrData | input | 5 | Status write data; 0 requests a clear |
| statRdData | output | 5 | Status flags |
| txTrigSel | input | 2 | Transmit trigger level select |
| rxTrigSel | input | 2 | Receive trigger level select |
| txPop | input | 1 | Word moved from transmit FIFO to shifter |
| txCount | input | 5 | Transmit FIFO fill count |
| rxPush | input | 1 | Word moved from receive shifter into FIFO |
| rxCount | input | 5 | Receive FIFO fill count |
| rxDrEvt | input | 1 | Data-ready event pulse |
| rxErrEvt | input | 1 | Receive error event pulse |
| rxBrkEvt | input | 1 | Break event pulse |
| txIrq | output | 1 | Transmit interrupt request |
| rxIrq | output | 1 | Receive interrupt request |
| errIrq | output | 1 | Receive error interrupt request |
| brkIrq | output | 1 | Break interrupt request |

## Verification
A hardware set event and a software clear can land on the same flag in the same clock. The bench provokes this by arming the data-ready and break flags with a read. It then issues a status write of 0 in the same cycle as a data-ready event pulse. It expects data-ready to stay set while break, which got no event, clears. A second kind of collision is a read that arms a marker followed by a write of 1. The bench judges it by following that write with a plain write of 0 and checking that the flag survives both.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;

  localparam int FLAG_W  = 5;
  localparam int F_DR    = 0;
  localparam int F_RXF   = 1;
  localparam int F_BRK   = 2;
  localparam int F_TXE   = 3;
  localparam int F_ERR   = 4;

  localparam int CTRL_TIE = 7;
  localparam int CTRL_RIE = 6;

  typedef struct packed {
    logic              ctrlWr;
    logic [FLAG_W-1:0] clrReq;
  } flagStrobe_t;

endpackage

// File: rtl/uart_flag_trig.sv
module uart_flag_trig #(
  parameter int CNT_W   = 5,
  parameter int SEL_W   = 2,
  parameter bit ABOVE   = 1'b1
) (
  input  logic [CNT_W-1:0] count,
  input  logic [SEL_W-1:0] sel,
  output logic             hit
);

  logic [CNT_W-1:0] level;

  assign level = CNT_W'(1) << sel;

  generate
    if (ABOVE) begin : g_above
      assign hit = count > level;
    end else begin : g_below
      assign hit = count < level;
    end
  endgenerate

endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
  import uart_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic              statRdEn,
  input  logic              statWrEn,
  input  logic [FLAG_W-1:0] statWrData,
  input  logic [FLAG_W-1:0] flags,
  output flagStrobe_t       strobe
);

  logic [FLAG_W-1:0] armQ;

  // Read-as-1 markers: a read reloads them from the live flags,
  // any status write consumes them.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armQ <= '0;
    end else if (statRdEn) begin
      armQ <= flags;
    end else if (statWrEn) begin
      armQ <= '0;
    end
  end

  always_comb begin
    strobe.ctrlWr = ctrlWrEn;
    for (int i = 0; i < FLAG_W; i++) begin
      strobe.clrReq[i] = statWrEn & ~statWrData[i] & armQ[i];
    end
  end

endmodule

// File: rtl/uart_flag_dp.sv
module uart_flag_dp
  import uart_flag_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrobe_t       strobe,
  input  logic [REG_W-1:0]  ctrlWrData,
  input  logic [FLAG_W-1:0] setEvt,
  input  logic [FLAG_W-1:0] clrOk,
  output logic [FLAG_W-1:0] flags,
  output logic [REG_W-1:0]  ctrlReg,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              errIrq,
  output logic              brkIrq
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (strobe.ctrlWr) begin
      ctrlReg <= ctrlWrData;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < FLAG_W; gi++) begin : g_flag
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          flags[gi] <= 1'b0;
        end else if (setEvt[gi]) begin
          flags[gi] <= 1'b1;
        end else if (strobe.clrReq[gi] && clrOk[gi]) begin
          flags[gi] <= 1'b0;
        end
      end
    end
  endgenerate

  logic tie;
  logic rie;
  assign tie = ctrlReg[CTRL_TIE];
  assign rie = ctrlReg[CTRL_RIE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txIrq  <= 1'b0;
      rxIrq  <= 1'b0;
      errIrq <= 1'b0;
      brkIrq <= 1'b0;
    end else begin
      txIrq  <= tie & flags[F_TXE];
      rxIrq  <= rie & (flags[F_RXF] | flags[F_DR]);
      errIrq <= rie & flags[F_ERR];
      brkIrq <= rie & flags[F_BRK];
    end
  end

endmodule

// File: rtl/uart_flag_irq.sv
module uart_flag_irq
  import uart_flag_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int CNT_W = 5,
  parameter int SEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [REG_W-1:0]  ctrlWrData,
  output logic [REG_W-1:0]  ctrlRdData,
  input  logic              statRdEn,
  input  logic              statWrEn,
  input  logic [FLAG_W-1:0] statWrData,
  output logic [FLAG_W-1:0] statRdData,
  input  logic [SEL_W-1:0]  txTrigSel,
  input  logic [SEL_W-1:0]  rxTrigSel,
  input  logic              txPop,
  input  logic [CNT_W-1:0]  txCount,
  input  logic              rxPush,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic              rxDrEvt,
  input  logic              rxErrEvt,
  input  logic              rxBrkEvt,
  output logic              txIrq,
  output logic              rxIrq,
  output logic              errIrq,
  output logic              brkIrq
);

  flagStrobe_t       strobe;
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] setEvt;
  logic [FLAG_W-1:0] clrOk;
  logic              txSetHit, txClrHit, rxSetHit, rxClrHit;

  uart_flag_trig #(.CNT_W(CNT_W), .SEL_W(SEL_W), .ABOVE(1'b0)) txSet_i (
    .count(txCount), .sel(txTrigSel), .hit(txSetHit));
  uart_flag_trig #(.CNT_W(CNT_W), .SEL_W(SEL_W), .ABOVE(1'b1)) txClr_i (
    .count(txCount), .sel(txTrigSel), .hit(txClrHit));
  uart_flag_trig #(.CNT_W(CNT_W), .SEL_W(SEL_W), .ABOVE(1'b1)) rxSet_i (
    .count(rxCount), .sel(rxTrigSel), .hit(rxSetHit));
  uart_flag_trig #(.CNT_W(CNT_W), .SEL_W(SEL_W), .ABOVE(1'b0)) rxClr_i (
    .count(rxCount), .sel(rxTrigSel), .hit(rxClrHit));

  always_comb begin
    setEvt         = '0;
    setEvt[F_DR]   = rxDrEvt;
    setEvt[F_RXF]  = rxPush & rxSetHit;
    setEvt[F_BRK]  = rxBrkEvt;
    setEvt[F_TXE]  = txPop & txSetHit;
    setEvt[F_ERR]  = rxErrEvt;
    clrOk          = '1;
    clrOk[F_RXF]   = rxClrHit;
    clrOk[F_TXE]   = txClrHit;
  end

  uart_flag_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .statRdEn(statRdEn),
    .statWrEn(statWrEn), .statWrData(statWrData), .flags(flags),
    .strobe(strobe));

  uart_flag_dp #(.REG_W(REG_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .ctrlWrData(ctrlWrData),
    .setEvt(setEvt), .clrOk(clrOk), .flags(flags), .ctrlReg(ctrlRdData),
    .txIrq(txIrq), .rxIrq(rxIrq), .errIrq(errIrq), .brkIrq(brkIrq));

  assign statRdData = flags;

endmodule

// File: rtl/uart_flag_irq_chk.sv
module uart_flag_irq_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] ctrlRdData,
  input logic       statWrEn,
  input logic [4:0] statWrData,
  input logic [4:0] statRdData,
  input logic [1:0] txTrigSel,
  input logic [1:0] rxTrigSel,
  input logic       txPop,
  input logic [4:0] txCount,
  input logic [4:0] rxCount,
  input logic       rxErrEvt,
  input logic       txIrq,
  input logic       rxIrq,
  input logic       errIrq,
  input logic       brkIrq
);

  logic [4:0] txLvl;
  logic [4:0] rxLvl;
  assign txLvl = 5'd1 << txTrigSel;
  assign rxLvl = 5'd1 << rxTrigSel;

  AST_TXE_SET: assert property (@(posedge clk) disable iff (!rstN)
    (txPop && (txCount < txLvl)) |=> statRdData[3]); // R2

  AST_TXIRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> ($past(ctrlRdData[7]) && $past(statRdData[3]))); // R3

  AST_TXE_CLR_WR0: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statRdData[3]) |-> ($past(statWrEn) && !$past(statWrData[3]))); // R4

  AST_TXE_CLR_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statRdData[3]) |-> ($past(txCount) > $past(txLvl))); // R4

  AST_RX_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !$past(ctrlRdData[6]) |-> !(rxIrq || errIrq || brkIrq)); // R6

  AST_RXF_CLR_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statRdData[1]) |-> ($past(rxCount) < $past(rxLvl))); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    rxErrEvt |=> statRdData[4]); // R9

endmodule

bind uart_flag_irq uart_flag_irq_chk chk_i (.*);

// File: tb/uart_flag_irq_tb_top.sv
`timescale 1ns/1ps
module uart_flag_irq_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWrEn = 1'b0;
  logic [7:0] ctrlWrData = '0;
  logic [7:0] ctrlRdData;
  logic       statRdEn = 1'b0;
  logic       statWrEn = 1'b0;
  logic [4:0] statWrData = '0;
  logic [4:0] statRdData;
  logic [1:0] txTrigSel = 2'd2;
  logic [1:0] rxTrigSel = 2'd1;
  logic       txPop = 1'b0;
  logic [4:0] txCount = 5'd8;
  logic       rxPush = 1'b0;
  logic [4:0] rxCount = 5'd0;
  logic       rxDrEvt = 1'b0;
  logic       rxErrEvt = 1'b0;
  logic       rxBrkEvt = 1'b0;
  logic       txIrq, rxIrq, errIrq, brkIrq;

  always #2 clk = ~clk;

  uart_flag_irq dut_i (.*);

  typedef struct {
    string      req;
    logic [4:0] stat;
    logic [7:0] ctrl;
    logic [3:0] irq;   // {brk, err, rx, tx}
  } expItem_t;

  expItem_t expQ[$];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // monitor: pops each expectation and compares against live outputs
  initial begin
    forever begin
      wait (expQ.size() != 0);
      begin
        expItem_t e;
        logic [3:0] irqAct;
        e = expQ.pop_front();
        irqAct = {brkIrq, errIrq, rxIrq, txIrq};
        total++;
        if (statRdData !== e.stat || ctrlRdData !== e.ctrl || irqAct !== e.irq) begin
          bad++;
          $display("FAIL %s: stat=%h ctrl=%h irq=%b expected stat=%h ctrl=%h irq=%b",
                   e.req, statRdData, ctrlRdData, irqAct, e.stat, e.ctrl, e.irq);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expectNow(string req, logic [4:0] s, logic [7:0] c, logic [3:0] i);
    expItem_t e;
    tick();   // let the registered interrupts follow the flags
    e.req = req; e.stat = s; e.ctrl = c; e.irq = i;
    expQ.push_back(e);
    #1;
  endtask

  task automatic wrCtrl(logic [7:0] d);
    ctrlWrEn = 1'b1; ctrlWrData = d; tick(); ctrlWrEn = 1'b0;
  endtask

  task automatic rdStat();
    statRdEn = 1'b1; tick(); statRdEn = 1'b0;
  endtask

  task automatic wrStat(logic [4:0] d);
    statWrEn = 1'b1; statWrData = d; tick(); statWrEn = 1'b0;
  endtask

  task automatic pushTx(logic [4:0] cnt);
    txCount = cnt; txPop = 1'b1; tick(); txPop = 1'b0;
  endtask

  task automatic pushRx(logic [4:0] cnt);
    rxCount = cnt; rxPush = 1'b1; tick(); rxPush = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    expectNow("R1 reset", 5'h00, 8'h00, 4'b0000);
    wrCtrl(8'hC0);
    expectNow("R1 ctrl readback", 5'h00, 8'hC0, 4'b0000);

    pushTx(5'd5);
    expectNow("R2 no set at count 5 level 4", 5'h00, 8'hC0, 4'b0000);
    pushTx(5'd3);
    expectNow("R2 R3 set below level", 5'h08, 8'hC0, 4'b0001);
    wrCtrl(8'h40);
    expectNow("R3 enable off drops txIrq", 5'h08, 8'h40, 4'b0000);
    wrCtrl(8'hC0);
    expectNow("R3 enable back on", 5'h08, 8'hC0, 4'b0001);

    txCount = 5'd8;
    wrStat(5'h00);
    expectNow("R8 write0 without read", 5'h08, 8'hC0, 4'b0001);
    rdStat(); wrStat(5'h1F);
    expectNow("R9 write1 ignored", 5'h08, 8'hC0, 4'b0001);
    wrStat(5'h00);
    expectNow("R8 marker consumed", 5'h08, 8'hC0, 4'b0001);
    txCount = 5'd3;
    rdStat(); wrStat(5'h00);
    expectNow("R4 clear refused at level", 5'h08, 8'hC0, 4'b0001);
    txCount = 5'd8;
    rdStat(); wrStat(5'h00);
    expectNow("R4 clear accepted", 5'h00, 8'hC0, 4'b0000);

    pushRx(5'd2);
    expectNow("R5 no set at level", 5'h00, 8'hC0, 4'b0000);
    pushRx(5'd3);
    expectNow("R5 set above level", 5'h02, 8'hC0, 4'b0010);
    rdStat(); wrStat(5'h00);
    expectNow("R7 rx clear refused", 5'h02, 8'hC0, 4'b0010);
    rxCount = 5'd1;
    rdStat(); wrStat(5'h00);
    expectNow("R7 rx clear accepted", 5'h00, 8'hC0, 4'b0000);

    rxDrEvt = 1'b1; rxErrEvt = 1'b1; rxBrkEvt = 1'b1; tick();
    rxDrEvt = 1'b0; rxErrEvt = 1'b0; rxBrkEvt = 1'b0;
    expectNow("R11 R6 events set flags", 5'h15, 8'hC0, 4'b1110);
    wrCtrl(8'h80);
    expectNow("R6 rx enable masks", 5'h15, 8'h80, 4'b0000);
    wrCtrl(8'hC0);
    expectNow("R6 rx enable restored", 5'h15, 8'hC0, 4'b1110);
    rdStat(); wrStat(5'h0F);
    expectNow("R7 error cleared alone", 5'h05, 8'hC0, 4'b1010);

    rdStat();
    statWrEn = 1'b1; statWrData = 5'h00; rxDrEvt = 1'b1; tick();
    statWrEn = 1'b0; rxDrEvt = 1'b0;
    expectNow("R9 set beats clear", 5'h01, 8'hC0, 4'b0010);

    txTrigSel = 2'd3;
    pushTx(5'd7);
    expectNow("R10 tx level 8", 5'h09, 8'hC0, 4'b0011);
    rxTrigSel = 2'd3;
    pushRx(5'd8);
    expectNow("R10 rx at level 8", 5'h09, 8'hC0, 4'b0011);
    pushRx(5'd9);
    expectNow("R10 rx above level 8", 5'h0B, 8'hC0, 4'b0011);

    wait (expQ.size() == 0);
    #1;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule